// File: doc/BRIEF.md
# Event Wake-up Mask Filter

This block stands between external event sources and a processor core. It receives 64 interrupt request lines and 20 DMA request lines. Each line reaches the core only while its mask bit is 0. Software never writes a mask directly. It reads the mask through three status words and changes it through two kinds of write-only strobe words: a clear word opens events, and a set word blocks them.

Filter interrupt bit n drives core event number n+45. To make this visible, the interrupt output port is indexed by core event number, so `core_irq_o[73]` carries filter bit 28. Core events 0 to 44 belong to the core and never pass through this block. The register port is a plain 32-bit bus with an address, a write enable, write data and read data. Read data is combinational on the address.

Top module: `evw_filter`

## Requirements
- R1: During and after reset every mask bit is 1 (status words read 0xFFFFFFFF, 0xFFFFFFFF and 0x000FFFFF), the config word reads 0, and every gated output is 0.
- R2: Status word 0x060 returns interrupt mask bits 0–31, 0x064 returns bits 32–63, and 0x068 returns DMA mask bits 0–19 in data bits 0–19.
- R3: Writing data to 0x070, 0x074 or 0x078 clears each mask bit whose data bit is 1, in the corresponding status word. This opens those events.
- R4: Writing data to 0x080, 0x084 or 0x088 sets each mask bit whose data bit is 1, in the corresponding status word. This blocks those events.
- R5: Data bits written as 0 to a set or clear word leave their mask bits unchanged. Set and clear words read back as 0.
- R6: Each gated output equals its raw request AND NOT its mask bit, registered with one clock of latency.
- R7: Interrupt filter bit n appears on output `core_irq_o[n+45]`.
- R8: Word 0x000 always reads 0x00010200, and writes to it are ignored.
- R9: Word 0x008 is a 32-bit read/write config word that has no effect on gating.
- R10: DMA status bits 20–31 read 0, and writes to those bit positions are ignored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_req_i | input | 64 | Raw interrupt requests |
| dma_req_i | input | 20 | Raw DMA requests |
| core_irq_o | output | 64 | Gated interrupts, indexed 45..108 by core event number |
| core_dma_o | output | 20 | Gated DMA requests |

## Verification
A vector table applies clear and set writes to all three mask words with these patterns:
- A byte-wide field.
- Both edge bits of the upper word.
- An all-ones word that also covers the reserved DMA bits.
- A write of zero.

These patterns tell a correct bitwise clear or set apart from a whole-word load, from an inverted sense, and from writes that leak into reserved bits. Gating is then tried in three ways:
- All requests high against a mixed mask, which separates the mask polarity from the request polarity.
- A single request at filter bit 28 with a one-cycle-early sample, which checks both the offset numbering and the register latency.
- A config write made between two gating checks, which shows that the config word has no effect on gating.

// File: rtl/evw_pkg.sv
package evw_pkg;
    localparam int DW = 32;
    localparam int AW = 12;

    localparam logic [AW-1:0] OFS_REV  = 12'h000;
    localparam logic [AW-1:0] OFS_CFG  = 12'h008;
    localparam logic [AW-1:0] OFS_STAT = 12'h060;
    localparam logic [AW-1:0] OFS_CLR  = 12'h070;
    localparam logic [AW-1:0] OFS_SET  = 12'h080;

    localparam logic [DW-1:0] REV_VALUE = 32'h0001_0200;
endpackage

// File: rtl/evw_mask_bank.sv
module evw_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] mask_o
);
    // Reset blocks every event; strobes only touch bits written as 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '1;
        end else begin
            mask_o <= (mask_o | set_i) & ~clr_i;
        end
    end
endmodule

// File: rtl/evw_gate.sv
module evw_gate #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] out_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_o <= '0;
        end else begin
            out_o <= req_i & ~mask_i;
        end
    end
endmodule

// File: rtl/evw_regif.sv
module evw_regif
    import evw_pkg::*;
#(
    parameter int NIRQ = 64,
    parameter int NDMA = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr_i,
    input  logic            we_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [NIRQ-1:0] irq_mask_i,
    input  logic [NDMA-1:0] dma_mask_i,
    output logic [NIRQ-1:0] irq_set_o,
    output logic [NIRQ-1:0] irq_clr_o,
    output logic [NDMA-1:0] dma_set_o,
    output logic [NDMA-1:0] dma_clr_o,
    output logic [DW-1:0]   rdata_o
);
    localparam int IW = NIRQ / DW;   // interrupt mask words
    localparam int NW = IW + 1;      // plus one DMA word

    logic [DW-1:0] cfg_q;
    logic [DW-1:0] stat_w [NW];
    logic [NW-1:0] hit_clr, hit_set;

    genvar w;
    generate
        for (w = 0; w < NW; w++) begin : g_word
            localparam logic [AW-1:0] A_CLR = OFS_CLR + AW'(4 * w);
            localparam logic [AW-1:0] A_SET = OFS_SET + AW'(4 * w);
            assign hit_clr[w] = we_i && (addr_i == A_CLR);
            assign hit_set[w] = we_i && (addr_i == A_SET);
            if (w < IW) begin : g_irq
                assign stat_w[w] = irq_mask_i[w*DW +: DW];
                assign irq_clr_o[w*DW +: DW] = hit_clr[w] ? wdata_i : '0;
                assign irq_set_o[w*DW +: DW] = hit_set[w] ? wdata_i : '0;
            end else begin : g_dma
                assign stat_w[w] = {{(DW-NDMA){1'b0}}, dma_mask_i};
                assign dma_clr_o = hit_clr[w] ? wdata_i[NDMA-1:0] : '0;
                assign dma_set_o = hit_set[w] ? wdata_i[NDMA-1:0] : '0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we_i && addr_i == OFS_CFG) begin
            cfg_q <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == OFS_REV) rdata_o = REV_VALUE;
        if (addr_i == OFS_CFG) rdata_o = cfg_q;
        for (int i = 0; i < NW; i++) begin
            if (addr_i == OFS_STAT + AW'(4 * i)) rdata_o = stat_w[i];
        end
    end
endmodule

// File: rtl/evw_filter.sv
module evw_filter
    import evw_pkg::*;
#(
    parameter int NIRQ     = 64,
    parameter int NDMA     = 20,
    parameter int EVT_BASE = 45
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [AW-1:0]                    bus_addr,
    input  logic                             bus_we,
    input  logic [DW-1:0]                    bus_wdata,
    output logic [DW-1:0]                    bus_rdata,
    input  logic [NIRQ-1:0]                  irq_req_i,
    input  logic [NDMA-1:0]                  dma_req_i,
    output logic [EVT_BASE+NIRQ-1:EVT_BASE]  core_irq_o,
    output logic [NDMA-1:0]                  core_dma_o
);
    logic [NIRQ-1:0] irq_mask, irq_set, irq_clr, irq_gated;
    logic [NDMA-1:0] dma_mask, dma_set, dma_clr;

    evw_regif #(.NIRQ(NIRQ), .NDMA(NDMA)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .addr_i(bus_addr), .we_i(bus_we), .wdata_i(bus_wdata),
        .irq_mask_i(irq_mask), .dma_mask_i(dma_mask),
        .irq_set_o(irq_set), .irq_clr_o(irq_clr),
        .dma_set_o(dma_set), .dma_clr_o(dma_clr),
        .rdata_o(bus_rdata)
    );

    evw_mask_bank #(.W(NIRQ)) u_irq_mask (
        .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr), .mask_o(irq_mask)
    );

    evw_mask_bank #(.W(NDMA)) u_dma_mask (
        .clk(clk), .rst_n(rst_n), .set_i(dma_set), .clr_i(dma_clr), .mask_o(dma_mask)
    );

    evw_gate #(.W(NIRQ)) u_irq_gate (
        .clk(clk), .rst_n(rst_n), .req_i(irq_req_i), .mask_i(irq_mask), .out_o(irq_gated)
    );

    evw_gate #(.W(NDMA)) u_dma_gate (
        .clk(clk), .rst_n(rst_n), .req_i(dma_req_i), .mask_i(dma_mask), .out_o(core_dma_o)
    );

    // Filter bit n lands on core event n + EVT_BASE.
    assign core_irq_o = irq_gated;
endmodule

// File: rtl/evw_filter_chk.sv
module evw_filter_chk
    import evw_pkg::*;
#(
    parameter int NIRQ = 64,
    parameter int NDMA = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_we,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [NDMA-1:0] dma_req_i,
    input logic [NDMA-1:0] core_dma_o,
    input logic [NIRQ-1:0] irq_mask,
    input logic [NDMA-1:0] dma_mask
);
    // R3: clear strobe on the low interrupt word zeroes the written bits
    a_r3_clear_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CLR) |=> ((irq_mask[31:0] & $past(bus_wdata)) == '0));

    // R4: set strobe on the DMA word raises the written bits
    a_r4_set_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_SET + 12'h008) |=>
        ((dma_mask & $past(bus_wdata[NDMA-1:0])) == $past(bus_wdata[NDMA-1:0])));

    // R5: without a write the masks hold
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(irq_mask) && $stable(dma_mask)));

    // R6: gated DMA output follows request and mask one clock later
    a_r6_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (core_dma_o == ($past(dma_req_i) & ~$past(dma_mask))));

    // R8: revision word is constant
    a_r8_rev: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_REV) |-> (bus_rdata == REV_VALUE));

    // R10: reserved DMA status bits read zero
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_STAT + 12'h008) |-> (bus_rdata[DW-1:NDMA] == '0));
endmodule

bind evw_filter evw_filter_chk #(.NIRQ(NIRQ), .NDMA(NDMA)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req_i(dma_req_i), .core_dma_o(core_dma_o),
    .irq_mask(irq_mask), .dma_mask(dma_mask)
);

// File: tb/evw_filter_tb.sv
module evw_filter_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [63:0]  irq_req_i = '0;
    logic [19:0]  dma_req_i = '0;
    logic [108:45] core_irq_o;
    logic [19:0]  core_dma_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evw_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req_i(irq_req_i), .dma_req_i(dma_req_i),
        .core_irq_o(core_irq_o), .core_dma_o(core_dma_o)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{12'h070, 32'h0000_00FF, 12'h060, 32'hFFFF_FF00, 8'd3},  // R3 clear low byte
        '{12'h080, 32'h0000_000F, 12'h060, 32'hFFFF_FF0F, 8'd4},  // R4 set nibble
        '{12'h074, 32'h8000_0001, 12'h064, 32'h7FFF_FFFE, 8'd3},  // R3 edge bits, R2 upper word
        '{12'h078, 32'hFFFF_FFFF, 12'h068, 32'h0000_0000, 8'd10}, // R10 reserved ignore
        '{12'h088, 32'hFFF0_0003, 12'h068, 32'h0000_0003, 8'd4},  // R4 dma set, R10
        '{12'h080, 32'h0000_0000, 12'h060, 32'hFFFF_FF0F, 8'd5},  // R5 zero write
        '{12'h070, 32'h0000_0000, 12'h080, 32'h0000_0000, 8'd5},  // R5 set word reads 0
        '{12'h008, 32'hA5A5_0001, 12'h008, 32'hA5A5_0001, 8'd9},  // R9 config rw
        '{12'h000, 32'h0000_DEAD, 12'h000, 32'h0001_0200, 8'd8},  // R8 revision
        '{12'h100, 32'h0000_1234, 12'h100, 32'h0000_0000, 8'd10}  // R10 unmapped
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 values while reset is asserted
        bus_read(12'h060, rd); check("R1 stat0 in reset", 64'(rd), 64'hFFFF_FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(12'h064, rd); check("R1 stat1", 64'(rd), 64'hFFFF_FFFF);
        bus_read(12'h068, rd); check("R1 stat2", 64'(rd), 64'h000F_FFFF);
        bus_read(12'h008, rd); check("R1 config", 64'(rd), 64'h0);
        irq_req_i = '1; dma_req_i = '1;
        @(negedge clk); @(negedge clk);
        check("R1 irq blocked", 64'(core_irq_o), 64'h0);
        check("R1 dma blocked", 64'(core_dma_o), 64'h0);
        irq_req_i = '0; dma_req_i = '0;

        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i].wa, VEC[i].wd);
            bus_read(VEC[i].ra, rd);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), 64'(rd), 64'(VEC[i].exp));
        end

        // R6: all requests high; masks low=FFFFFF0F high=7FFFFFFE dma=00003
        irq_req_i = '1; dma_req_i = '1;
        #1;
        check("R6 latency irq", 64'(core_irq_o), 64'h0);
        @(negedge clk);
        check("R6 irq gate", 64'(core_irq_o), ~{32'h7FFF_FFFE, 32'hFFFF_FF0F});
        check("R6 dma gate", 64'(core_dma_o), 64'(20'hFFFFC));

        // R9: config write leaves gating alone
        bus_write(12'h008, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R9 dma unchanged", 64'(core_dma_o), 64'(20'hFFFFC));
        check("R9 irq unchanged", 64'(core_irq_o), ~{32'h7FFF_FFFE, 32'hFFFF_FF0F});

        // R7: filter bit 28 maps to core event 73
        irq_req_i = 64'h0000_0000_1000_0000;
        bus_write(12'h070, 32'h1000_0000);
        @(negedge clk);
        check("R7 event 73", 64'(core_irq_o[73]), 64'h1);
        check("R7 vector", 64'(core_irq_o), 64'h0000_0000_1000_0000);
        // R4: blocking again removes it after one clock
        bus_write(12'h080, 32'h1000_0000);
        @(negedge clk);
        check("R4 event 73 blocked", 64'(core_irq_o[73]), 64'h0);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(12'h068, rd); check("R1 re-reset stat2", 64'(rd), 64'h000F_FFFF);
        bus_read(12'h060, rd); check("R1 re-reset stat0", 64'(rd), 64'hFFFF_FFFF);
        check("R1 re-reset dma out", 64'(core_dma_o), 64'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule